// File: doc/BRIEF.md
# Dependency-Group Instruction Issuer

This block keeps a small set of instruction queues, one per group, and dispatches them onto a fixed number of issue lanes. Each group carries a mask of the groups it waits on. After a start pulse, every instruction that can go is sent out in the earliest possible cycle. Instructions leave one group strictly in the order they were pushed. Different groups proceed independently of one another and can overtake each other. A group that waits on several others, and is itself waited on by later groups, acts as a barrier between two phases of work.

Execution is not modelled in detail. Each instruction carries a latency tag in its low bits. The issuer tracks how long each group still has work in flight. A group counts as finished only when its last instruction has completed, not when it was sent. When every group has finished, the issuer stops and holds the total number of cycles the run took.

The number of groups (4) and lanes (2) are set in the package. The queue depth, instruction width, tag width and latency counter width are parameters of the top.

Top module: `groupIssuer`

## Requirements
- R1: Out of reset, `laneValid`, `groupDone`, `running`, `finished` and `totalLatency` are all zero.
- R2: A push writes `pushInstr` to the tail of the queue of group `pushGroup`. A push to a queue that already holds `QDEPTH` entries is dropped and never issued.
- R3: A group issues its instructions in push order, at most one per cycle. While the group stays ready, consecutive instructions go out on consecutive clock edges.
- R4: At most `NUM_LANES` instructions issue per edge. Ready groups are served in ascending group ID. The lowest ready ID goes to lane 0, the next one to lane 1, and a lane k is only valid if lane k-1 is.
- R5: A group whose prerequisite mask is zero issues its first instruction on the first edge after the start edge.
- R6: A group with a nonzero prerequisite mask (bit j set means group j is a prerequisite) waits for all of those prerequisites. Its first instruction issues on the edge right after the edge that sets the `groupDone` bit of its last prerequisite.
- R7: The latency tag is `instr[TAG_W-1:0]`, and a value of 0 counts as 1. An instruction with latency L issued on edge e completes on edge e+L. A group's `groupDone` bit is set on the first edge at which its queue is empty and all of its issued instructions have completed. An empty group is done on the first edge at which its prerequisites are met. `groupDone` bits stay set until the next start.
- R8: `finished` rises, and `running` falls, on the edge that sets the last `groupDone` bit. `totalLatency` then holds the number of edges from the start edge (excluded) to that edge (included), and stays stable until the next start.
- R9: A start pulse while `running` is high is ignored and does not disturb the run or its latency count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pushValid | input | 1 | Push an instruction into a group queue |
| pushGroup | input | GID_W | Target group of the push |
| pushInstr | input | INSTR_W | Instruction word; low TAG_W bits are the latency tag |
| cfgValid | input | 1 | Write the prerequisite mask of a group (when not running) |
| cfgGroup | input | GID_W | Group whose mask is written |
| cfgPrereq | input | NUM_GROUPS | Prerequisite mask, bit j = waits on group j |
| start | input | 1 | Begin a run |
| laneValid | output | NUM_LANES | Lane carries an instruction issued on the last edge |
| laneGroup | output | NUM_LANES*GID_W | Group ID per lane, lane 0 in the low bits |
| laneInstr | output | NUM_LANES*INSTR_W | Instruction per lane, lane 0 in the low bits |
| groupDone | output | NUM_GROUPS | Per-group finished flags |
| running | output | 1 | A run is in progress |
| finished | output | 1 | The last run has completed |
| totalLatency | output | LAT_W | Edge count of the last run |

## Verification
The bench builds the block with its defaults: four groups, two lanes, queues four deep and a four-bit latency tag. Three groups ready at once against two lanes exercises the ID-ordered arbitration. Five pushes into one four-deep queue reach the drop-on-full case. A five-cycle tag makes the wait on completion visibly longer than the wait on issue. A two-level barrier chain, an all-empty run, zero tags and a start pulse during a run cover the remaining timing rules.

// File: rtl/issuePkg.sv
package issuePkg;
  localparam int NUM_GROUPS = 4;
  localparam int NUM_LANES  = 2;
  localparam int GID_W      = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1;

  typedef logic [GID_W-1:0] gid_t;

  // Strobes from control to the datapath for one cycle.
  typedef struct packed {
    logic [NUM_GROUPS-1:0]  pop;   // dequeue head of group
    logic [NUM_LANES-1:0]   fire;  // lane carries an issue
    gid_t [NUM_LANES-1:0]   sel;   // group routed to lane
  } strobe_t;
endpackage

// File: rtl/issueDatapath.sv
module issueDatapath
  import issuePkg::*;
#(
  parameter int QDEPTH  = 4,
  parameter int INSTR_W = 16,
  parameter int TAG_W   = 4,
  localparam int CNT_W  = $clog2(QDEPTH + 1),
  localparam int PTR_W  = (QDEPTH > 1) ? $clog2(QDEPTH) : 1
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  logic                                 pushValid,
  input  gid_t                                 pushGroup,
  input  logic [INSTR_W-1:0]                   pushInstr,
  input  strobe_t                              strobe,
  output logic [NUM_GROUPS-1:0][TAG_W-1:0]     headTag,
  output logic [NUM_GROUPS-1:0][CNT_W-1:0]     qCount,
  output logic [NUM_LANES-1:0]                 laneValid,
  output gid_t [NUM_LANES-1:0]                 laneGroup,
  output logic [NUM_LANES-1:0][INSTR_W-1:0]    laneInstr
);

  logic [NUM_GROUPS-1:0][INSTR_W-1:0] headInstr;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : gQueue
    logic [INSTR_W-1:0] mem [QDEPTH];
    logic [PTR_W-1:0]   wrPtr, rdPtr;
    logic [CNT_W-1:0]   count;
    logic               pushHit, popHit;

    assign pushHit = pushValid && (pushGroup == gid_t'(g)) && (count < CNT_W'(QDEPTH));
    assign popHit  = strobe.pop[g];

    always_ff @(posedge clk) begin
      if (pushHit) mem[wrPtr] <= pushInstr;
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        wrPtr <= '0;
        rdPtr <= '0;
        count <= '0;
      end else begin
        if (pushHit) wrPtr <= (wrPtr == PTR_W'(QDEPTH - 1)) ? '0 : wrPtr + 1'b1;
        if (popHit)  rdPtr <= (rdPtr == PTR_W'(QDEPTH - 1)) ? '0 : rdPtr + 1'b1;
        case ({pushHit, popHit})
          2'b10:   count <= count + 1'b1;
          2'b01:   count <= count - 1'b1;
          default: count <= count;
        endcase
      end
    end

    assign headInstr[g] = mem[rdPtr];
    assign headTag[g]   = mem[rdPtr][TAG_W-1:0];
    assign qCount[g]    = count;

    // R2: control never dequeues an empty queue
    p_no_underflow_r2: assert property (@(posedge clk) disable iff (!rstN)
      popHit |-> (count != '0));
  end

  for (genvar l = 0; l < NUM_LANES; l++) begin : gLane
    always_ff @(posedge clk) begin
      if (!rstN) begin
        laneValid[l] <= 1'b0;
        laneGroup[l] <= '0;
        laneInstr[l] <= '0;
      end else begin
        laneValid[l] <= strobe.fire[l];
        laneGroup[l] <= strobe.sel[l];
        laneInstr[l] <= headInstr[strobe.sel[l]];
      end
    end

    if (l > 0) begin : gPack
      // R4: lanes fill from lane 0 upward with ascending group IDs
      p_lane_pack_r4: assert property (@(posedge clk) disable iff (!rstN)
        laneValid[l] |-> (laneValid[l-1] && (laneGroup[l] > laneGroup[l-1])));
    end
  end

endmodule

// File: rtl/issueControl.sv
module issueControl
  import issuePkg::*;
#(
  parameter int TAG_W = 4,
  parameter int CNT_W = 3,
  parameter int LAT_W = 16
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              cfgValid,
  input  gid_t                              cfgGroup,
  input  logic [NUM_GROUPS-1:0]             cfgPrereq,
  input  logic                              start,
  input  logic [NUM_GROUPS-1:0][TAG_W-1:0]  headTag,
  input  logic [NUM_GROUPS-1:0][CNT_W-1:0]  qCount,
  output strobe_t                           strobe,
  output logic [NUM_GROUPS-1:0]             groupDone,
  output logic                              running,
  output logic                              finished,
  output logic [LAT_W-1:0]                  totalLatency
);

  logic [NUM_GROUPS-1:0][NUM_GROUPS-1:0] prereq;
  logic [NUM_GROUPS-1:0][TAG_W-1:0]      rem, remNext;
  logic [NUM_GROUPS-1:0]                 prereqMet, ready, doneSet;
  logic                                  allDoneNext;
  logic [LAT_W-1:0]                      latCnt;

  // Readiness and in-order, ID-priority lane assignment.
  always_comb begin
    int unsigned laneIdx;
    strobe  = '0;
    laneIdx = 0;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      prereqMet[g] = ((prereq[g] & ~groupDone) == '0);
      ready[g]     = running && !groupDone[g] && prereqMet[g] && (qCount[g] != '0);
      if (ready[g] && (laneIdx < NUM_LANES)) begin
        strobe.pop[g]         = 1'b1;
        strobe.fire[laneIdx]  = 1'b1;
        strobe.sel[laneIdx]   = gid_t'(g);
        laneIdx               = laneIdx + 1;
      end
    end
  end

  // Outstanding-work tracking: remaining cycles until the group's
  // latest-completing issued instruction is done.
  always_comb begin
    for (int g = 0; g < NUM_GROUPS; g++) begin
      logic [TAG_W-1:0] lat, dec;
      logic             lastGone;
      lat        = (headTag[g] == '0) ? TAG_W'(1) : headTag[g];
      dec        = (rem[g] != '0) ? rem[g] - 1'b1 : '0;
      remNext[g] = (strobe.pop[g] && (lat > dec)) ? lat : dec;
      lastGone   = (qCount[g] == '0) || ((qCount[g] == CNT_W'(1)) && strobe.pop[g]);
      doneSet[g] = running && !groupDone[g] && prereqMet[g] && lastGone && (remNext[g] == '0);
    end
    allDoneNext = &(groupDone | doneSet);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prereq    <= '0;
      rem       <= '0;
      groupDone <= '0;
      running   <= 1'b0;
      finished  <= 1'b0;
      latCnt    <= '0;
    end else begin
      if (cfgValid && !running) prereq[cfgGroup] <= cfgPrereq;
      if (start && !running) begin
        running   <= 1'b1;
        finished  <= 1'b0;
        groupDone <= '0;
        rem       <= '0;
        latCnt    <= '0;
      end else if (running) begin
        rem       <= remNext;
        groupDone <= groupDone | doneSet;
        latCnt    <= latCnt + 1'b1;
        if (allDoneNext) begin
          running  <= 1'b0;
          finished <= 1'b1;
        end
      end
    end
  end

  assign totalLatency = latCnt;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : gChk
    // R7: a finished flag stays set for the rest of the run
    p_done_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
      (running && groupDone[g]) |=> groupDone[g]);
  end

  // R8: completion implies every group is done
  p_finish_all_r8: assert property (@(posedge clk) disable iff (!rstN)
    finished |-> (&groupDone));

  // R8: latency holds once the run is over
  p_lat_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (finished && !start) |=> $stable(latCnt));

  // R9: a start during a run only advances the count by one
  p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rstN)
    (running && start && !allDoneNext) |=> (running && latCnt == $past(latCnt) + 1'b1));

endmodule

// File: rtl/groupIssuer.sv
module groupIssuer
  import issuePkg::*;
#(
  parameter int QDEPTH  = 4,
  parameter int INSTR_W = 16,
  parameter int TAG_W   = 4,
  parameter int LAT_W   = 16,
  localparam int CNT_W  = $clog2(QDEPTH + 1)
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           pushValid,
  input  logic [GID_W-1:0]               pushGroup,
  input  logic [INSTR_W-1:0]             pushInstr,
  input  logic                           cfgValid,
  input  logic [GID_W-1:0]               cfgGroup,
  input  logic [NUM_GROUPS-1:0]          cfgPrereq,
  input  logic                           start,
  output logic [NUM_LANES-1:0]           laneValid,
  output logic [NUM_LANES*GID_W-1:0]     laneGroup,
  output logic [NUM_LANES*INSTR_W-1:0]   laneInstr,
  output logic [NUM_GROUPS-1:0]          groupDone,
  output logic                           running,
  output logic                           finished,
  output logic [LAT_W-1:0]               totalLatency
);

  strobe_t                             strobe;
  logic [NUM_GROUPS-1:0][TAG_W-1:0]    headTag;
  logic [NUM_GROUPS-1:0][CNT_W-1:0]    qCount;
  gid_t [NUM_LANES-1:0]                laneGroupArr;
  logic [NUM_LANES-1:0][INSTR_W-1:0]   laneInstrArr;

  issueControl #(.TAG_W(TAG_W), .CNT_W(CNT_W), .LAT_W(LAT_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .cfgValid(cfgValid), .cfgGroup(cfgGroup), .cfgPrereq(cfgPrereq),
    .start(start), .headTag(headTag), .qCount(qCount),
    .strobe(strobe), .groupDone(groupDone), .running(running),
    .finished(finished), .totalLatency(totalLatency)
  );

  issueDatapath #(.QDEPTH(QDEPTH), .INSTR_W(INSTR_W), .TAG_W(TAG_W)) u_data (
    .clk(clk), .rstN(rstN),
    .pushValid(pushValid), .pushGroup(pushGroup), .pushInstr(pushInstr),
    .strobe(strobe), .headTag(headTag), .qCount(qCount),
    .laneValid(laneValid), .laneGroup(laneGroupArr), .laneInstr(laneInstrArr)
  );

  assign laneGroup = laneGroupArr;
  assign laneInstr = laneInstrArr;

endmodule

// File: tb/groupIssuer_tb.sv
module groupIssuer_tb;
  import issuePkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int IW = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pushValid = 1'b0;
  logic [GID_W-1:0] pushGroup = '0;
  logic [IW-1:0] pushInstr = '0;
  logic cfgValid = 1'b0;
  logic [GID_W-1:0] cfgGroup = '0;
  logic [NUM_GROUPS-1:0] cfgPrereq = '0;
  logic start = 1'b0;
  logic [NUM_LANES-1:0] laneValid;
  logic [NUM_LANES*GID_W-1:0] laneGroup;
  logic [NUM_LANES*IW-1:0] laneInstr;
  logic [NUM_GROUPS-1:0] groupDone;
  logic running, finished;
  logic [15:0] totalLatency;

  int errors = 0;
  int checks = 0;
  int edgeCnt = 0;
  int e0Cnt = 0;
  bit tracking = 1'b0;
  int issueCyc [64];
  int issueLane [64];
  int issueGrp [64];
  int doneCyc [NUM_GROUPS];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) edgeCnt <= edgeCnt + 1;

  groupIssuer u_dut (
    .clk(clk), .rstN(rstN), .pushValid(pushValid), .pushGroup(pushGroup),
    .pushInstr(pushInstr), .cfgValid(cfgValid), .cfgGroup(cfgGroup),
    .cfgPrereq(cfgPrereq), .start(start), .laneValid(laneValid),
    .laneGroup(laneGroup), .laneInstr(laneInstr), .groupDone(groupDone),
    .running(running), .finished(finished), .totalLatency(totalLatency)
  );

  // Issue and completion log, sampled away from the active edge.
  always @(negedge clk) begin
    if (tracking) begin
      for (int l = 0; l < NUM_LANES; l++) begin
        if (laneValid[l]) begin
          int id;
          id = int'(laneInstr[l*IW+4 +: 6]);
          issueCyc[id]  = edgeCnt - e0Cnt;
          issueLane[id] = l;
          issueGrp[id]  = int'(laneGroup[l*GID_W +: GID_W]);
        end
      end
      for (int g = 0; g < NUM_GROUPS; g++)
        if (groupDone[g] && doneCyc[g] < 0) doneCyc[g] = edgeCnt - e0Cnt;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfg(input int g, input logic [NUM_GROUPS-1:0] mask);
    @(negedge clk);
    cfgValid = 1'b1; cfgGroup = GID_W'(g); cfgPrereq = mask;
    @(negedge clk);
    cfgValid = 1'b0;
  endtask

  task automatic push(input int g, input int id, input int tag);
    @(negedge clk);
    pushValid = 1'b1; pushGroup = GID_W'(g);
    pushInstr = IW'((id << 4) | (tag & 15));
    @(negedge clk);
    pushValid = 1'b0;
  endtask

  task automatic clearMasks();
    for (int g = 0; g < NUM_GROUPS; g++) cfg(g, '0);
  endtask

  task automatic run(input bit midStart);
    int guard;
    for (int i = 0; i < 64; i++) begin issueCyc[i] = -1; issueLane[i] = -1; issueGrp[i] = -1; end
    for (int g = 0; g < NUM_GROUPS; g++) doneCyc[g] = -1;
    @(negedge clk);
    start = 1'b1;
    @(posedge clk);
    #1;
    e0Cnt = edgeCnt;
    tracking = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (midStart) begin
      repeat (2) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    guard = 0;
    while (!finished && guard < 200) begin
      @(negedge clk);
      guard++;
    end
    repeat (2) @(negedge clk);
    tracking = 1'b0;
  endtask

  task automatic testReset();
    chk("R1 laneValid", int'(laneValid), 0);
    chk("R1 groupDone", int'(groupDone), 0);
    chk("R1 running", int'(running), 0);
    chk("R1 finished", int'(finished), 0);
    chk("R1 totalLatency", int'(totalLatency), 0);
  endtask

  task automatic testInOrder();
    clearMasks();
    push(0, 1, 3); push(0, 2, 1); push(0, 3, 2);
    run(1'b0);
    chk("R3 id1 cycle", issueCyc[1], 1);
    chk("R3 id2 cycle", issueCyc[2], 2);
    chk("R3 id3 cycle", issueCyc[3], 3);
    chk("R5 id1 lane", issueLane[1], 0);
    chk("R7 g0 done", doneCyc[0], 5);
    chk("R7 empty g1 done", doneCyc[1], 1);
    chk("R8 latency", int'(totalLatency), 5);
    chk("R8 finished", int'(finished), 1);
    chk("R8 running low", int'(running), 0);
  endtask

  task automatic testLanes();
    clearMasks();
    push(0, 4, 1); push(1, 5, 1); push(2, 6, 1);
    run(1'b0);
    chk("R4 id4 cycle", issueCyc[4], 1);
    chk("R4 id4 lane", issueLane[4], 0);
    chk("R4 id5 cycle", issueCyc[5], 1);
    chk("R4 id5 lane", issueLane[5], 1);
    chk("R4 id5 group", issueGrp[5], 1);
    chk("R4 id6 cycle", issueCyc[6], 2);
    chk("R4 id6 lane", issueLane[6], 0);
    chk("R8 latency", int'(totalLatency), 3);
  endtask

  task automatic testBarrier();
    clearMasks();
    cfg(2, 4'b0011);
    cfg(3, 4'b0100);
    push(0, 7, 2); push(1, 8, 1); push(1, 9, 1);
    push(2, 10, 1); push(3, 11, 1);
    run(1'b0);
    chk("R5 id7 cycle", issueCyc[7], 1);
    chk("R4 id8 lane", issueLane[8], 1);
    chk("R3 id9 cycle", issueCyc[9], 2);
    chk("R7 g0 done", doneCyc[0], 3);
    chk("R7 g1 done", doneCyc[1], 3);
    chk("R6 id10 cycle", issueCyc[10], 4);
    chk("R6 id11 cycle", issueCyc[11], 6);
    chk("R7 g3 done", doneCyc[3], 7);
    chk("R8 latency", int'(totalLatency), 7);
  endtask

  task automatic testCompletion();
    clearMasks();
    cfg(1, 4'b0001);
    push(0, 12, 5); push(1, 13, 1);
    run(1'b1);
    chk("R7 g0 done", doneCyc[0], 6);
    chk("R6 id13 cycle", issueCyc[13], 7);
    chk("R9 latency", int'(totalLatency), 8);
  endtask

  task automatic testFullZeroTag();
    clearMasks();
    for (int i = 0; i < 5; i++) push(0, 20 + i, 0);
    run(1'b0);
    chk("R2 id23 cycle", issueCyc[23], 4);
    chk("R2 dropped id24", issueCyc[24], -1);
    chk("R7 zero tag done", doneCyc[0], 5);
    chk("R8 latency", int'(totalLatency), 5);
  endtask

  task automatic testAllEmpty();
    clearMasks();
    run(1'b0);
    chk("R7 all empty done", int'(groupDone), 15);
    chk("R8 latency", int'(totalLatency), 1);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testInOrder();
    testLanes();
    testBarrier();
    testCompletion();
    testFullZeroTag();
    testAllEmpty();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule